// File: doc/BRIEF.md
# Settling-Aware Sinc Decimation Filter

The block turns a one-bit oversampled modulator stream, one bit per clock, into signed output words at a reduced rate. A mode input selects either a third-order or a first-order sinc response. A two-bit rate field and a clock-range bit together select the decimation ratio R. R is always a power of two between 32 and 256. Each output word is scaled so that full scale does not depend on R or on the filter order. A one-cycle valid pulse marks each new word.

A ready flag tells a host when the current word is settled data. Any change of the configuration inputs restarts the filter. The flag then stays low until enough outputs have passed for the filter memory to hold only new samples: three outputs for the third-order response and one for the first-order response. A sync input holds the filter cleared while it is high and leaves the ready flag alone. A read strobe clears the flag. Releasing sync starts the settling count again from zero.

Top module: `sinc_decim`

## Requirements
- R1: With mode_i = 0, the sum S is the third-order sinc sum of the bits (a bit 1 counts as 1, a bit 0 as 0) over the last R-sample blocks. Each word equals floor((S - R^3/2) * 2^(17 - 3k)), where R = 2^k. For a repeating bit pattern whose period divides R and whose fraction of ones is d, settled words equal 2^17 * (d - 1/2).
- R2: With mode_i = 1, the same rule holds with first order: S is the count of ones in the last R samples, and the word is floor((S - R/2) * 2^(17 - k)).
- R3: k equals 5 + fs_i when clkrange_i = 1. When clkrange_i = 0, k is 5 for fs_i = 0 and 4 + fs_i otherwise. valid_o pulses for one cycle after the edge that takes the R-th sample after a restart, and again every R samples after that.
- R4: In third-order mode the first two outputs after a restart drive ready_o low. The third and every later output drive ready_o high in the same cycle as valid_o.
- R5: In first-order mode every output, including the first after a restart, drives ready_o high with valid_o.
- R6: A change of mode_i, fs_i or clkrange_i restarts the filter at that edge and discards that cycle's bit. It also clears ready_o at that edge. A change from first to third order therefore needs three outputs before ready_o returns.
- R7: While sync_i is high the filter stays cleared, no valid_o pulse appears and ready_o keeps its value. The first output comes R samples after release.
- R8: A high rd_i clears ready_o at the next edge when no output is produced at that edge, including while sync_i is high.
- R9: When rd_i is high at the edge that produces a settled output, ready_o is 1 after that edge.
- R10: Reset drives data_o, valid_o and ready_o to 0. The stored configuration resets to fs_i = 01, clkrange_i = 1, mode_i = 0, so inputs held at those values cause no restart when reset is released. The first valid_o then comes after the 64th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one modulator bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| mod_bit_i | input | 1 | Modulator output bit |
| mode_i | input | 1 | 0: third-order sinc, 1: first-order sinc |
| fs_i | input | 2 | Rate field, selects R with clkrange_i |
| clkrange_i | input | 1 | Clock-range bit, selects R with fs_i |
| sync_i | input | 1 | Holds the filter cleared while high |
| rd_i | input | 1 | Read strobe, clears the ready flag |
| data_o | output | OUT_W | Signed output word |
| valid_o | output | 1 | One-cycle pulse per new word |
| ready_o | output | 1 | High while the held word is settled and unread |

## Verification
A read strobe and a settled output can arrive at the same edge. In that case the new word must win and ready_o must stay high. To provoke this, rd_i is raised in the cycle that carries the R-th sample of a block, at a point where the flag is already high from the previous output. The flag is then judged on the new output. A sync hold and a read strobe can also overlap. Here the flag must survive hundreds of held cycles and then drop only when the strobe is applied.

// File: rtl/sincdec_pkg.sv
package sincdec_pkg;

  localparam int unsigned NSTAGE = 3;

  // log2 of the decimation ratio from clock-range bit and rate field
  function automatic logic [3:0] ratio_log2(input logic ck, input logic [1:0] fs,
                                            input int unsigned kmin);
    logic [3:0] base;
    base = 4'(kmin);
    if (ck)
      return base + {2'b00, fs};
    else if (fs == 2'd0)
      return base;
    else
      return base + {2'b00, fs} - 4'd1;
  endfunction

endpackage

// File: rtl/sincdec_ctrl.sv
module sincdec_ctrl #(
  parameter int unsigned KMIN  = 5,
  parameter int unsigned CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_i,
  input  logic [1:0] fs_i,
  input  logic       ck_i,
  input  logic       sync_i,
  input  logic       rd_i,
  output logic [3:0] k_o,
  output logic       restart_o,
  output logic       tap_o,
  output logic       ready_o
);
  import sincdec_pkg::*;

  logic [3:0]       cfg_q;
  logic [3:0]       cfg_now;
  logic             cfg_chg;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [1:0]       sc_q;
  logic             settled;

  assign cfg_now   = {mode_i, fs_i, ck_i};
  assign cfg_chg   = (cfg_now != cfg_q);
  assign restart_o = sync_i | cfg_chg;
  assign k_o       = ratio_log2(ck_i, fs_i, KMIN);
  assign lim       = CNT_W'((32'd1 << k_o) - 32'd1);
  assign tap_o     = !restart_o && (cnt_q == lim);
  assign settled   = mode_i || (sc_q >= 2'd2);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= {1'b0, 2'b01, 1'b1};
      cnt_q <= '0;
      sc_q  <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (restart_o || tap_o)
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + 1'b1;
      if (restart_o)
        sc_q <= '0;
      else if (tap_o && sc_q != 2'd3)
        sc_q <= sc_q + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ready_o <= 1'b0;
    else if (cfg_chg)
      ready_o <= 1'b0;
    else if (tap_o)
      ready_o <= settled;
    else if (rd_i)
      ready_o <= 1'b0;
  end

  AST_CFG_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> !ready_o); // R6
  AST_SYNC_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
    (sync_i && !cfg_chg && !rd_i) |=> (ready_o == $past(ready_o))); // R7
  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !tap_o) |=> !ready_o); // R8
  AST_EARLY_OUTPUT_UNREADY: assert property (@(posedge clk) disable iff (rst)
    (tap_o && !mode_i && sc_q < 2'd2) |=> !ready_o); // R4
  AST_SETTLED_BEATS_READ: assert property (@(posedge clk) disable iff (rst)
    (tap_o && rd_i && (mode_i || sc_q >= 2'd2)) |=> ready_o); // R9

endmodule

// File: rtl/sincdec_integ.sv
module sincdec_integ #(
  parameter int unsigned ACC_W = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             bit_i,
  output logic [ACC_W-1:0] tap1_o,
  output logic [ACC_W-1:0] tapn_o
);
  import sincdec_pkg::*;

  logic [ACC_W-1:0] acc_q [NSTAGE];
  logic [ACC_W-1:0] acc_n [NSTAGE];

  // chained next-state sums: each stage sees this cycle's bit at once
  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign acc_n[s] = acc_q[s] + {{(ACC_W-1){1'b0}}, bit_i};
    end else begin : g_rest
      assign acc_n[s] = acc_q[s] + acc_n[s-1];
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTAGE; s++) begin
      if (rst || clr_i)
        acc_q[s] <= '0;
      else
        acc_q[s] <= acc_n[s];
    end
  end

  assign tap1_o = acc_n[0];
  assign tapn_o = acc_n[NSTAGE-1];

endmodule

// File: rtl/sincdec_comb.sv
module sincdec_comb #(
  parameter int unsigned ACC_W = 25,
  parameter int unsigned OUT_W = 18
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_i,
  input  logic                    tap_i,
  input  logic                    mode_i,
  input  logic [3:0]              k_i,
  input  logic [ACC_W-1:0]        tap1_i,
  input  logic [ACC_W-1:0]        tapn_i,
  output logic signed [OUT_W-1:0] data_o,
  output logic                    valid_o
);
  import sincdec_pkg::*;

  localparam int unsigned SH_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0]        x0;
  logic [ACC_W-1:0]        dl_q [NSTAGE];
  logic [ACC_W-1:0]        cs   [NSTAGE];
  logic [ACC_W-1:0]        sum;
  logic [SH_W-1:0]         nk;
  logic [SH_W-1:0]         shamt;
  logic signed [ACC_W:0]   half;
  logic signed [ACC_W:0]   centred;
  logic signed [ACC_W:0]   scaled;

  assign x0 = mode_i ? tap1_i : tapn_i;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_diff
    if (s == 0) begin : g_first
      assign cs[s] = x0 - dl_q[s];
    end else begin : g_rest
      assign cs[s] = cs[s-1] - dl_q[s];
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTAGE; s++) begin
      if (rst || clr_i)
        dl_q[s] <= '0;
      else if (tap_i)
        dl_q[s] <= (s == 0) ? x0 : cs[s-1];
    end
  end

  // centre around zero, then align full scale to the accumulator top bit
  assign sum     = mode_i ? cs[0] : cs[NSTAGE-1];
  assign nk      = mode_i ? SH_W'(k_i) : SH_W'(NSTAGE * k_i);
  assign half    = (ACC_W+1)'(1) <<< (nk - 1'b1);
  assign centred = $signed({1'b0, sum}) - half;
  assign shamt   = SH_W'(ACC_W - 1) - nk;
  assign scaled  = centred <<< shamt;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= tap_i;
      if (tap_i)
        data_o <= scaled[ACC_W-1 -: OUT_W];
    end
  end

  AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R3

endmodule

// File: rtl/sinc_decim.sv
module sinc_decim #(
  parameter int unsigned OUT_W = 18,
  parameter int unsigned KMIN  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mod_bit_i,
  input  logic                    mode_i,
  input  logic [1:0]              fs_i,
  input  logic                    clkrange_i,
  input  logic                    sync_i,
  input  logic                    rd_i,
  output logic signed [OUT_W-1:0] data_o,
  output logic                    valid_o,
  output logic                    ready_o
);
  import sincdec_pkg::*;

  localparam int unsigned KMAX  = KMIN + 3;
  localparam int unsigned ACC_W = NSTAGE * KMAX + 1;
  localparam int unsigned CNT_W = KMAX;

  logic [3:0]       k;
  logic             restart;
  logic             tap;
  logic [ACC_W-1:0] tap1;
  logic [ACC_W-1:0] tapn;

  sincdec_ctrl #(.KMIN(KMIN), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode_i), .fs_i(fs_i), .ck_i(clkrange_i),
    .sync_i(sync_i), .rd_i(rd_i), .k_o(k), .restart_o(restart), .tap_o(tap),
    .ready_o(ready_o)
  );

  sincdec_integ #(.ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst(rst), .clr_i(restart), .bit_i(mod_bit_i),
    .tap1_o(tap1), .tapn_o(tapn)
  );

  sincdec_comb #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_comb (
    .clk(clk), .rst(rst), .clr_i(restart), .tap_i(tap), .mode_i(mode_i),
    .k_i(k), .tap1_i(tap1), .tapn_i(tapn), .data_o(data_o), .valid_o(valid_o)
  );

  AST_SYNC_BLOCKS_VALID: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> !valid_o); // R7
  AST_READY_RISES_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> valid_o); // R4

endmodule

// File: tb/tb_sinc_decim.sv
`timescale 1ns/1ps
module tb_sinc_decim;

  logic clk = 1'b0;
  logic rst, mod_i, mode_i, ck_i, sync_i, rd_i;
  logic [1:0] fs_i;
  logic signed [17:0] data_o;
  logic valid_o, ready_o;

  always #2.5 clk = ~clk;

  sinc_decim dut (
    .clk(clk), .rst(rst), .mod_bit_i(mod_i), .mode_i(mode_i), .fs_i(fs_i),
    .clkrange_i(ck_i), .sync_i(sync_i), .rd_i(rd_i),
    .data_o(data_o), .valid_o(valid_o), .ready_o(ready_o)
  );

  typedef struct {
    int    cyc;
    bit    chkd;
    int    data;
    bit    rdy;
    string tc;
    string td;
    string tr;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   nchk = 0;
  int   nfail = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // monitor: pop one expected item per valid pulse
  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (sb.size() == 0) begin
        check(0, "R3", "unexpected valid at cycle", cyc, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.cyc, e.tc, "valid cycle", cyc, e.cyc);
        if (e.chkd)
          check(int'(data_o) == e.data, e.td, "data word", int'(data_o), e.data);
        check(ready_o == e.rdy, e.tr, "ready with valid", ready_o, e.rdy);
      end
    end
  end

  function automatic int klog(input bit ck, input bit [1:0] fs);
    if (ck) return 5 + fs;
    if (fs == 0) return 5;
    return 4 + fs;
  endfunction

  // driver: one segment of a steady 4-bit repeating pattern
  task automatic seg(input bit m, input bit [1:0] f, input bit ck, input bit use_sync,
                     input bit restart, input bit [3:0] pat, input int nout,
                     input int rd_out, input int pre_rdy,
                     input string tc, input string td, input string tr);
    int r, need, base, val;
    r    = 1 << klog(ck, f);
    need = m ? 1 : 3;
    val  = 32768 * $countones(pat) - 65536;
    mode_i = m; fs_i = f; ck_i = ck; sync_i = use_sync;
    if (restart) begin
      @(posedge clk);
      @(negedge clk);
      sync_i = 1'b0;
      if (pre_rdy >= 0)
        check(ready_o == pre_rdy[0], use_sync ? "R7" : "R6", "ready after restart edge",
              ready_o, pre_rdy);
    end
    base = cyc;
    for (int n = 1; n <= nout; n++) begin
      exp_t e;
      e.cyc  = base + n * r;
      e.chkd = (n >= need);
      e.data = val;
      e.rdy  = (n >= need);
      e.tc   = tc;
      e.td   = td;
      e.tr   = (n == rd_out) ? "R9" : tr;
      sb.push_back(e);
    end
    for (int j = 0; j < nout * r; j++) begin
      mod_i = pat[j % 4];
      rd_i  = (rd_out > 0) && (j == rd_out * r - 1);
      @(negedge clk);
    end
    rd_i   = 1'b0;
    sync_i = 1'b1;
  endtask

  initial begin
    #500000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mod_i = 1'b0; mode_i = 1'b0; fs_i = 2'b01; ck_i = 1'b1;
    sync_i = 1'b0; rd_i = 1'b0;
    repeat (4) @(negedge clk);
    check(valid_o == 1'b0, "R10", "valid in reset", valid_o, 0);
    check(ready_o == 1'b0, "R10", "ready in reset", ready_o, 0);
    check(data_o == 18'sd0, "R10", "data in reset", data_o, 0);
    rst = 1'b0;
    // defaults: no restart, R = 64, third order, all ones
    seg(0, 2'b01, 1, 0, 0, 4'b1111, 4, 0, -1, "R10", "R1", "R4");
    // pure sync restart keeps ready; read coincides with settled output 4
    seg(0, 2'b01, 1, 1, 1, 4'b0000, 4, 4, 1, "R7", "R1", "R4");
    repeat (300) @(negedge clk);
    check(ready_o == 1'b1, "R7", "ready held through long sync", ready_o, 1);
    // config change to first order clears ready
    seg(1, 2'b10, 1, 0, 1, 4'b1010, 2, 0, 0, "R3", "R2", "R5");
    // first to third order: needs three outputs
    seg(0, 2'b10, 1, 0, 1, 4'b1110, 4, 0, 0, "R3", "R1", "R6");
    // read during sync
    rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    check(ready_o == 1'b0, "R8", "ready after read in sync", ready_o, 0);
    @(negedge clk);
    check(ready_o == 1'b0, "R8", "ready stays low after read", ready_o, 0);
    // ratio sweep in first order
    for (int c = 0; c < 2; c++)
      for (int f = 0; f < 4; f++)
        seg(1, 2'(f), c[0], 1, 1, 4'b1100, 2, 0, -1, "R3", "R2", "R5");
    seg(0, 2'b11, 1, 1, 1, 4'b0111, 3, 0, -1, "R3", "R1", "R4");
    seg(0, 2'b00, 0, 1, 1, 4'b1000, 3, 0, -1, "R3", "R1", "R4");
    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R3", "outputs still expected", sb.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

endmodule